// File: doc/BRIEF.md
# Invert-Controlled Integer ALU

This block is a purely combinational arithmetic-logic unit for a 32-bit integer datapath. A 4-bit operation code picks one of six functions: bitwise AND, bitwise OR, addition, subtraction, signed set-on-less-than and bitwise NOR. The operand width is a parameter with a default of 32.

The six functions are not built as six separate circuits. One shared core has an AND plane, an OR plane and a ripple adder, and two conditioning flags sit in front of it. The top bit of the code complements operand A. The next bit complements operand B and also supplies the adder carry-in. The low two bits choose which core output drives the result. As a result, subtract is A plus the complement of B plus one, and NOR is the AND of both complemented operands.

The block also drives a zero flag, which a branch-equal unit uses to resolve a comparison. Any code that is not one of the six defined codes gives a result of 0.

Top module: `alu_inv_core`

## Requirements
- R1: Code 4'b0000 gives result = op_a & op_b.
- R2: Code 4'b0001 gives result = op_a | op_b.
- R3: Code 4'b0010 gives result = (op_a + op_b) mod 2^WIDTH, and any carry out of the top bit is dropped.
- R4: Code 4'b0110 gives result = (op_a - op_b) mod 2^WIDTH.
- R5: Code 4'b0111 gives 1 in bit 0 when op_a < op_b as two's-complement signed values, and 0 otherwise. Bits WIDTH-1..1 are always 0. The answer stays correct when op_a - op_b overflows.
- R6: Code 4'b1100 gives result = ~(op_a | op_b).
- R7: Every other code (0011, 0100, 0101, 1000–1011, 1101–1111) gives result = 0, whatever the operands are.
- R8: zero is 1 exactly when all bits of result are 0. This includes the undefined codes of R7.
- R9: The outputs depend only on the present inputs, with no clock or stored state. A new set of inputs shows at the outputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Operation: bit 3 complements A, bit 2 complements B and sets carry-in, bits 1..0 select the result (00 AND, 01 OR, 10 sum, 11 less-than) |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| result | output | WIDTH | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
A 4-bit copy of the block is swept over all 16 codes and every pair of operands. This sweep covers every sign combination for less-than, including each pair where the subtraction overflows. It is the case that separates a correct less-than from one that reads the raw sign of the difference. The same sweep shows that every undefined code gives 0 and therefore raises the zero flag. The 32-bit default is driven with chosen corner operands: extreme signed values, all-ones, carries that wrap, and equal operands. These tell apart carry-in errors, swapped inversion flags and a misplaced less-than bit at full width.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    SEL_AND = 2'b00,
    SEL_OR  = 2'b01,
    SEL_SUM = 2'b10,
    SEL_LT  = 2'b11
  } sel_e;

  localparam logic [3:0] CODE_AND = 4'b0000;
  localparam logic [3:0] CODE_OR  = 4'b0001;
  localparam logic [3:0] CODE_ADD = 4'b0010;
  localparam logic [3:0] CODE_SUB = 4'b0110;
  localparam logic [3:0] CODE_SLT = 4'b0111;
  localparam logic [3:0] CODE_NOR = 4'b1100;

  function automatic logic code_defined(input logic [3:0] c);
    return (c == CODE_AND) || (c == CODE_OR) || (c == CODE_ADD) ||
           (c == CODE_SUB) || (c == CODE_SLT) || (c == CODE_NOR);
  endfunction

endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic             flip_a,
  input  logic             flip_b,
  output logic [WIDTH-1:0] out_a,
  output logic [WIDTH-1:0] out_b
);

  always_comb begin
    out_a = flip_a ? ~in_a : in_a;
    out_b = flip_b ? ~in_b : in_b;
  end

endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             ovf
);

  logic [WIDTH:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum[i]     = x[i] ^ y[i] ^ carry[i];
    assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
  end

  // signed overflow: carry into the top bit differs from carry out of it
  assign ovf = carry[WIDTH] ^ carry[WIDTH-1];

endmodule

// File: rtl/alu_result_sel.sv
module alu_result_sel
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] cond_a,
  input  logic [WIDTH-1:0] cond_b,
  input  logic [WIDTH-1:0] sum,
  input  logic             ovf,
  input  sel_e             sel,
  input  logic             defined,
  output logic [WIDTH-1:0] result
);

  logic less;

  // true sign of the difference is the raw sign corrected by overflow
  assign less = sum[WIDTH-1] ^ ovf;

  always_comb begin
    result = '0;
    if (defined) begin
      unique case (sel)
        SEL_AND: result = cond_a & cond_b;
        SEL_OR:  result = cond_a | cond_b;
        SEL_SUM: result = sum;
        SEL_LT:  result = {{(WIDTH-1){1'b0}}, less};
        default: result = '0;
      endcase
    end
  end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] value,
  output logic             is_zero
);

  assign is_zero = ~|value;

endmodule

// File: rtl/alu_inv_core.sv
module alu_inv_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op_code,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] result,
  output logic             zero
);

  logic [WIDTH-1:0] cond_a;
  logic [WIDTH-1:0] cond_b;
  logic [WIDTH-1:0] sum;
  logic             ovf;
  logic             defined;
  sel_e             sel;

  assign defined = code_defined(op_code);
  assign sel     = sel_e'(op_code[1:0]);

  alu_operand_cond #(.WIDTH(WIDTH)) i_cond (
    .in_a   (op_a),
    .in_b   (op_b),
    .flip_a (op_code[3]),
    .flip_b (op_code[2]),
    .out_a  (cond_a),
    .out_b  (cond_b)
  );

  // carry-in tied to the B inversion flag: subtract becomes A + ~B + 1
  alu_ripple_adder #(.WIDTH(WIDTH)) i_adder (
    .x   (cond_a),
    .y   (cond_b),
    .cin (op_code[2]),
    .sum (sum),
    .ovf (ovf)
  );

  alu_result_sel #(.WIDTH(WIDTH)) i_sel (
    .cond_a  (cond_a),
    .cond_b  (cond_b),
    .sum     (sum),
    .ovf     (ovf),
    .sel     (sel),
    .defined (defined),
    .result  (result)
  );

  alu_zero_detect #(.WIDTH(WIDTH)) i_zero (
    .value   (result),
    .is_zero (zero)
  );

  always_comb begin
    if (op_code == CODE_ADD)
      AST_ADD_WRAPS: assert (result == WIDTH'(op_a + op_b)) else $error("add mismatch"); // R3
    if (op_code == CODE_SUB)
      AST_SUB_DIFF: assert (result == WIDTH'(op_a - op_b)) else $error("sub mismatch"); // R4
    if (op_code == CODE_SLT)
      AST_SLT_UPPER_CLEAR: assert (result[WIDTH-1:1] == '0) else $error("slt upper bits"); // R5
    if (op_code == CODE_SLT)
      AST_SLT_SIGNED: assert (result[0] == ($signed(op_a) < $signed(op_b))) else $error("slt value"); // R5
    if (op_code == CODE_NOR)
      AST_NOR_PLANE: assert (result == ~(op_a | op_b)) else $error("nor mismatch"); // R6
    if (!defined)
      AST_UNDEF_CLEAR: assert (result == '0) else $error("undefined code nonzero"); // R7
    AST_ZERO_FLAG: assert (zero == (result == '0)) else $error("zero flag"); // R8
  end

endmodule

// File: tb/test_alu_inv_core.sv
module test_alu_inv_core;

  localparam int W  = 32;
  localparam int WS = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [3:0]    code;
  logic [W-1:0]  a, b;
  logic [W-1:0]  res;
  logic          zf;

  logic [3:0]    s_code;
  logic [WS-1:0] s_a, s_b;
  logic [WS-1:0] s_res;
  logic          s_zf;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  alu_inv_core #(.WIDTH(W)) i_alu_inv_core (
    .op_code (code), .op_a (a), .op_b (b), .result (res), .zero (zf)
  );

  alu_inv_core #(.WIDTH(WS)) i_alu_inv_core_w4 (
    .op_code (s_code), .op_a (s_a), .op_b (s_b), .result (s_res), .zero (s_zf)
  );

  function automatic longint sx(input longint v, input int w);
    return v[w-1] ? v - (longint'(1) << w) : v;
  endfunction

  function automatic longint expect_res(input logic [3:0] c, input longint va,
                                        input longint vb, input int w);
    longint m = (longint'(1) << w) - 1;
    case (c)
      4'b0000: return va & vb;
      4'b0001: return va | vb;
      4'b0010: return (va + vb) & m;
      4'b0110: return (va - vb) & m;
      4'b0111: return (sx(va, w) < sx(vb, w)) ? 1 : 0;
      4'b1100: return (~(va | vb)) & m;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] c);
    case (c)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      4'b1100: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_wide(input logic [3:0] c, input logic [W-1:0] va,
                          input logic [W-1:0] vb);
    longint e;
    @(posedge clk);
    code = c; a = va; b = vb;
    @(negedge clk);
    e = expect_res(c, longint'(va), longint'(vb), W);
    check({req_of(c), " R9"}, longint'(res), e);
    check("R8", longint'(zf), (e == 0) ? 1 : 0);
  endtask

  initial begin
    code = 4'b0000; a = '0; b = '0;
    s_code = 4'b0000; s_a = '0; s_b = '0;
    @(negedge clk);
    check("R1 idle", longint'(res), 0);
    check("R8 idle", longint'(zf), 1);

    for (int c = 0; c < 16; c++) begin
      run_wide(4'(c), 32'h8000_0000, 32'h0000_0001);
      run_wide(4'(c), 32'h7FFF_FFFF, 32'hFFFF_FFFF);
      run_wide(4'(c), 32'hFFFF_FFFF, 32'h0000_0001);
      run_wide(4'(c), 32'hDEAD_BEEF, 32'hDEAD_BEEF);
      run_wide(4'(c), 32'h0F0F_00FF, 32'h3C3C_F00F);
      run_wide(4'(c), 32'h0000_0000, 32'hFFFF_FFFF);
    end

    for (int c = 0; c < 16; c++) begin
      for (int x = 0; x < (1 << WS); x++) begin
        for (int y = 0; y < (1 << WS); y++) begin
          longint e;
          @(posedge clk);
          s_code = 4'(c); s_a = WS'(x); s_b = WS'(y);
          @(negedge clk);
          e = expect_res(4'(c), longint'(x), longint'(y), WS);
          check(req_of(4'(c)), longint'(s_res), e);
          check("R8", longint'(s_zf), (e == 0) ? 1 : 0);
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    for (int cyc = 0; cyc < 150000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule